// File: doc/BRIEF.md
# Packet Timestamp Capture Bank

This block records the running 64-bit nanosecond time at the start of precision-time event frames, for both directions of a network port. The transmit side has one capture slot. The receive side has a pool of four slots. Each slot holds its stamp until software reads the slot's upper word. A small 32-bit register port lets software set up the capture rules and read back the stamps and the slot occupancy.

The receive path strobes `rx_sof` together with a classification of the frame: protocol version, whether it was carried over UDP, and the message type. If the frame passes the filter in the second control word, the block places the current time in the lowest-numbered free slot. One cycle later it reports back which slot it used, or it reports that the frame got no stamp. Once every receive slot is occupied, event frames go unstamped until software releases a slot. The transmit slot works the same way with a single entry, and it can raise a one-cycle interrupt pulse on each capture.

Top module: `pkt_tstamp_bank`

## Requirements
- R1: After reset all slots are free. The status word, both control words, `tx_irq`, `rx_done` and `rx_stamped` are all zero.
- R2: The second control word is at address 0x1. Bit 31 is the global capture enable, bits [1:0] select the version (1 or 2), bit 4 enables UDP recognition and bits [11:8] select the message type. It reads back exactly as written. With the enable clear, or with a version code other than 1 or 2, no receive frame is stamped.
- R3: In version-1 mode a frame is stamped only when it is version 1, carried over UDP, its message type equals the selection and UDP recognition is enabled. With UDP recognition disabled, version-1 mode stamps nothing.
- R4: In version-2 mode a version-2 frame whose message type matches is stamped when it is not carried over UDP. When it is carried over UDP, it is stamped only if UDP recognition is enabled. Frames of the other version are never stamped.
- R5: A stamped receive frame takes the lowest-numbered free slot and stores the value of `now_ns` at the clock edge that samples `rx_sof`. One cycle after `rx_sof`, `rx_done` is high, `rx_stamped` tells whether a stamp was taken and `rx_slot` gives the slot index.
- R6: The status word is at address 0x2. Bit i (0..3) is set while receive slot i is occupied, and bit 8 is set while the transmit slot is occupied. Reading the status word changes nothing.
- R7: Receive slot i has its lower word at address 8+2i and its upper word at address 9+2i. An occupied slot keeps its stamp. Reading the lower word frees nothing. Reading the upper word returns bits [63:32] and frees the slot from the next cycle.
- R8: While all four receive slots are occupied, a frame that passes the filter is reported with `rx_stamped` low. After one upper-word read, the next such frame gets the freed slot.
- R9: When `tx_sof` and `tx_is_event` are high, the global enable is set and the transmit slot is free, the transmit slot takes `now_ns`. Its lower word is at address 0x4 and its upper word at 0x5. Further transmit strobes are ignored until the upper word at 0x5 is read.
- R10: The first control word is at address 0x0. When its bit 0 is set, a transmit capture makes `tx_irq` high for exactly the one cycle after the capture edge. When bit 0 is clear, `tx_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ns | input | 64 | Running time in nanoseconds |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_is_event | input | 1 | Transmit frame is a timing event |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ver | input | 2 | Version of the received frame |
| rx_udp | input | 1 | Received frame is carried over UDP |
| rx_msg | input | 4 | Message type of the received frame |
| rx_done | output | 1 | Receive result is valid this cycle |
| rx_stamped | output | 1 | Received frame was given a slot |
| rx_slot | output | 2 | Slot index used for the received frame |
| tx_irq | output | 1 | Transmit capture interrupt pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current address |

## Verification
The bench fills the pool completely, so that the frame arriving while the pool is full must come back unstamped. A design that overwrote a slot or wrapped around would instead report a stamp there. It frees a slot in the middle of the pool and checks that the next frame lands in that slot and not at the end. This catches allocation that searches from the wrong side. It checks that reading the status word or a lower word leaves occupancy unchanged, and that a second transmit strobe leaves the held stamp intact. It also probes each filter case (UDP recognition off in each version, a message-type mismatch, an unknown version code), where a loose filter would fill slots it should leave empty.

// File: rtl/pts_pkg.sv
package pts_pkg;
  localparam int A_CTRL0  = 0;
  localparam int A_CTRL1  = 1;
  localparam int A_STAT   = 2;
  localparam int A_TXLO   = 4;
  localparam int A_TXHI   = 5;
  localparam int A_RXBASE = 8;

  localparam int C1_EN_BIT  = 31;
  localparam int C1_UDP_BIT = 4;
  localparam int C1_MSG_LSB = 8;
  localparam int STAT_TX_BIT = 8;

  typedef struct packed {
    logic       en;
    logic [1:0] ver;
    logic       udp_en;
    logic [3:0] msg;
  } rx_filt_t;

  function automatic logic filt_pass(rx_filt_t f, logic [1:0] ver, logic udp,
                                     logic [3:0] msg);
    logic ok;
    ok = 1'b0;
    if (f.en && (msg == f.msg)) begin
      case (f.ver)
        2'd1: ok = (ver == 2'd1) && udp && f.udp_en;
        2'd2: ok = (ver == 2'd2) && (!udp || f.udp_en);
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction
endpackage

// File: rtl/pts_ctrl.sv
module pts_ctrl
  import pts_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctrl0,
  output logic [WORD_W-1:0] ctrl1,
  output logic              irq_en,
  output rx_filt_t          filt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl0 <= '0;
      ctrl1 <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_CTRL0)) ctrl0 <= wdata;
      if (addr == ADDR_W'(A_CTRL1)) ctrl1 <= wdata;
    end
  end

  assign irq_en      = ctrl0[0];
  assign filt.en     = ctrl1[C1_EN_BIT];
  assign filt.ver    = ctrl1[1:0];
  assign filt.udp_en = ctrl1[C1_UDP_BIT];
  assign filt.msg    = ctrl1[C1_MSG_LSB +: 4];
endmodule

// File: rtl/pts_tx_slot.sv
module pts_tx_slot #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_req,
  input  logic            rel,
  input  logic [TS_W-1:0] now,
  output logic            locked,
  output logic            cap_evt,
  output logic [TS_W-1:0] stamp
);
  assign cap_evt = cap_req && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      stamp  <= '0;
    end else begin
      if (cap_evt) begin
        locked <= 1'b1;
        stamp  <= now;
      end else if (rel) begin
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pts_rx_pool.sv
module pts_rx_pool #(
  parameter int NUM_RX = 4,
  parameter int TS_W   = 64,
  localparam int IDX_W = $clog2(NUM_RX)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sof,
  input  logic                        pass,
  input  logic [NUM_RX-1:0]           rel_mask,
  input  logic [TS_W-1:0]             now,
  output logic [NUM_RX-1:0]           valid,
  output logic [NUM_RX-1:0]           set_mask,
  output logic [NUM_RX-1:0][TS_W-1:0] stamps,
  output logic                        rep_done,
  output logic                        rep_vld,
  output logic [IDX_W-1:0]            rep_idx
);
  function automatic logic [IDX_W-1:0] first_free(logic [NUM_RX-1:0] f);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_RX - 1; i >= 0; i--)
      if (f[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [NUM_RX-1:0] free_mask;
  logic              cap_ok;
  logic [IDX_W-1:0]  pick;

  assign free_mask = ~valid;
  assign cap_ok    = sof && pass && (|free_mask);
  assign pick      = first_free(free_mask);
  assign set_mask  = cap_ok ? (NUM_RX'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= '0;
      rep_done <= 1'b0;
      rep_vld  <= 1'b0;
      rep_idx  <= '0;
    end else begin
      valid    <= (valid & ~rel_mask) | set_mask;
      rep_done <= sof;
      rep_vld  <= cap_ok;
      rep_idx  <= cap_ok ? pick : '0;
    end
  end

  for (genvar g = 0; g < NUM_RX; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)           stamps[g] <= '0;
      else if (set_mask[g]) stamps[g] <= now;
    end
  end
endmodule

// File: rtl/pkt_tstamp_bank.sv
module pkt_tstamp_bank
  import pts_pkg::*;
#(
  parameter int NUM_RX = 4,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 5,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(NUM_RX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   now_ns,
  input  logic              tx_sof,
  input  logic              tx_is_event,
  input  logic              rx_sof,
  input  logic [1:0]        rx_ver,
  input  logic              rx_udp,
  input  logic [3:0]        rx_msg,
  output logic              rx_done,
  output logic              rx_stamped,
  output logic [IDX_W-1:0]  rx_slot,
  output logic              tx_irq,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata
);
  logic [WORD_W-1:0] ctrl0, ctrl1, stat_word;
  logic              irq_en;
  rx_filt_t          filt;
  logic              rx_pass;
  logic [NUM_RX-1:0] rx_valid, rx_set_mask, rx_rel_mask;
  logic [NUM_RX-1:0][TS_W-1:0] rx_stamps;
  logic              tx_locked, tx_cap_evt, tx_rel, tx_req;
  logic [TS_W-1:0]   tx_stamp;
  logic              stat_rd;
  logic              tx_irq_q;

  pts_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl0(ctrl0), .ctrl1(ctrl1), .irq_en(irq_en), .filt(filt)
  );

  assign rx_pass = filt_pass(filt, rx_ver, rx_udp, rx_msg);

  for (genvar g = 0; g < NUM_RX; g++) begin : g_rel
    assign rx_rel_mask[g] = reg_rd && (reg_addr == ADDR_W'(A_RXBASE + 2 * g + 1));
  end

  pts_rx_pool #(.NUM_RX(NUM_RX), .TS_W(TS_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .sof(rx_sof), .pass(rx_pass),
    .rel_mask(rx_rel_mask), .now(now_ns), .valid(rx_valid),
    .set_mask(rx_set_mask), .stamps(rx_stamps), .rep_done(rx_done),
    .rep_vld(rx_stamped), .rep_idx(rx_slot)
  );

  assign tx_req = tx_sof && tx_is_event && filt.en;
  assign tx_rel = reg_rd && (reg_addr == ADDR_W'(A_TXHI));

  pts_tx_slot #(.TS_W(TS_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cap_req(tx_req), .rel(tx_rel), .now(now_ns),
    .locked(tx_locked), .cap_evt(tx_cap_evt), .stamp(tx_stamp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tx_irq_q <= 1'b0;
    else        tx_irq_q <= tx_cap_evt && irq_en;
  end
  assign tx_irq = tx_irq_q;

  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(A_STAT));

  always_comb begin
    stat_word = '0;
    stat_word[NUM_RX-1:0]  = rx_valid;
    stat_word[STAT_TX_BIT] = tx_locked;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL0): reg_rdata = ctrl0;
      ADDR_W'(A_CTRL1): reg_rdata = ctrl1;
      ADDR_W'(A_STAT):  reg_rdata = stat_word;
      ADDR_W'(A_TXLO):  reg_rdata = WORD_W'(tx_stamp);
      ADDR_W'(A_TXHI):  reg_rdata = WORD_W'(tx_stamp >> WORD_W);
      default:          reg_rdata = '0;
    endcase
    for (int i = 0; i < NUM_RX; i++) begin
      if (reg_addr == ADDR_W'(A_RXBASE + 2 * i))
        reg_rdata = WORD_W'(rx_stamps[i]);
      if (reg_addr == ADDR_W'(A_RXBASE + 2 * i + 1))
        reg_rdata = WORD_W'(rx_stamps[i] >> WORD_W);
    end
  end
endmodule

// File: rtl/pts_chk.sv
module pts_chk #(
  parameter int NUM_RX = 4,
  parameter int TS_W   = 64,
  localparam int IDX_W = $clog2(NUM_RX)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_sof,
  input logic [NUM_RX-1:0] rx_valid,
  input logic [NUM_RX-1:0] rx_set_mask,
  input logic [NUM_RX-1:0] rx_rel_mask,
  input logic              rx_done,
  input logic              rx_stamped,
  input logic [IDX_W-1:0]  rx_slot,
  input logic              stat_rd,
  input logic              tx_locked,
  input logic              tx_rel,
  input logic [TS_W-1:0]   tx_stamp,
  input logic              tx_cap_evt,
  input logic              irq_en,
  input logic              tx_irq
);
  // R5
  rep_slot_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stamped |-> (rx_done && rx_valid[rx_slot]));
  // R5
  single_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_set_mask));
  // R7
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rel_mask != '0) |=> ((rx_valid & $past(rx_rel_mask)) == '0));
  // R8
  full_no_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && (&rx_valid)) |=> !rx_stamped);
  // R6
  stat_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (rx_set_mask == '0)) |=> $stable(rx_valid));
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_locked && !tx_rel) |=> (tx_locked && $stable(tx_stamp)));
  // R10
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(irq_en && tx_cap_evt));
  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cap_evt && irq_en) |=> tx_irq);
endmodule

bind pkt_tstamp_bank pts_chk #(.NUM_RX(NUM_RX), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
  .rx_set_mask(rx_set_mask), .rx_rel_mask(rx_rel_mask), .rx_done(rx_done),
  .rx_stamped(rx_stamped), .rx_slot(rx_slot), .stat_rd(stat_rd),
  .tx_locked(tx_locked), .tx_rel(tx_rel), .tx_stamp(tx_stamp),
  .tx_cap_evt(tx_cap_evt), .irq_en(irq_en), .tx_irq(tx_irq)
);

// File: tb/sim_pkt_tstamp_bank.sv
module sim_pkt_tstamp_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] now_ns = 64'h0000_0012_3456_7000;
  logic        tx_sof = 0, tx_is_event = 0, rx_sof = 0, rx_udp = 0;
  logic [1:0]  rx_ver = 0;
  logic [3:0]  rx_msg = 0;
  logic        rx_done, rx_stamped, tx_irq;
  logic [1:0]  rx_slot;
  logic        reg_wr = 0, reg_rd = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] exp_ts [4];
  logic [63:0] tx_exp;
  logic [31:0] d;

  typedef struct { bit st; logic [1:0] idx; logic [63:0] ts; } rx_exp_t;
  rx_exp_t exp_q[$];
  string   tag_q[$];
  bit      pend = 0;

  pkt_tstamp_bank u0 (
    .clk(clk), .rst_n(rst_n), .now_ns(now_ns), .tx_sof(tx_sof),
    .tx_is_event(tx_is_event), .rx_sof(rx_sof), .rx_ver(rx_ver),
    .rx_udp(rx_udp), .rx_msg(rx_msg), .rx_done(rx_done),
    .rx_stamped(rx_stamped), .rx_slot(rx_slot), .tx_irq(tx_irq),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;
  always @(posedge clk) now_ns <= now_ns + 64'd8;
  always @(posedge clk) pend <= rx_sof;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected receive report one cycle after each rx_sof
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      rx_exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " done"}, {63'd0, rx_done}, 64'd1);
      chk({t, " stamped"}, {63'd0, rx_stamped}, {63'd0, e.st});
      if (e.st) begin
        chk({t, " slot"}, {62'd0, rx_slot}, {62'd0, e.idx});
        exp_ts[e.idx] = e.ts;
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rx_pkt(logic [1:0] ver, bit udp, logic [3:0] msg, bit st,
                        logic [1:0] idx, string tag);
    rx_exp_t e;
    @(negedge clk);
    rx_ver = ver; rx_udp = udp; rx_msg = msg; rx_sof = 1;
    e.st = st; e.idx = idx; e.ts = now_ns;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rx_sof = 0;
    @(negedge clk);
  endtask

  task automatic tx_pkt(bit exp_irq, string tag);
    @(negedge clk); tx_sof = 1; tx_is_event = 1; tx_exp = now_ns;
    @(negedge clk); tx_sof = 0; tx_is_event = 0;
    chk({tag, " irq"}, {63'd0, tx_irq}, {63'd0, exp_irq});
    @(negedge clk);
    chk({tag, " irq pulse ends"}, {63'd0, tx_irq}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    chk("R1 rx_done", {63'd0, rx_done}, 0);
    chk("R1 rx_stamped", {63'd0, rx_stamped}, 0);
    chk("R1 tx_irq", {63'd0, tx_irq}, 0);
    rd(5'h2, d); chk("R1 status", {32'd0, d}, 0);
    rd(5'h1, d); chk("R1 ctrl1", {32'd0, d}, 0);
    rd(5'h0, d); chk("R1 ctrl0", {32'd0, d}, 0);

    // R2: enable clear -> no stamp
    rx_pkt(2, 1, 0, 0, 0, "R2 disabled");
    wr(5'h1, 32'h8000_0012);
    // R4 / R5
    rx_pkt(2, 1, 0, 1, 0, "R4 v2 udp");
    rx_pkt(2, 0, 0, 1, 1, "R4 v2 l2");
    rx_pkt(2, 1, 3, 0, 0, "R4 msg mismatch");
    rx_pkt(1, 1, 0, 0, 0, "R4 v1 in v2 mode");
    // R6
    rd(5'h2, d); chk("R6 status", {32'd0, d}, 64'h3);
    rd(5'h2, d); chk("R6 status reread", {32'd0, d}, 64'h3);
    // R7
    rd(5'd8, d); chk("R7 lo word", {32'd0, d}, {32'd0, exp_ts[0][31:0]});
    rd(5'h2, d); chk("R7 lo keeps slot", {32'd0, d}, 64'h3);
    rd(5'd9, d); chk("R7 hi word", {32'd0, d}, {32'd0, exp_ts[0][63:32]});
    rd(5'h2, d); chk("R7 hi frees slot", {32'd0, d}, 64'h2);
    rd(5'd10, d); chk("R7 slot1 held", {32'd0, d}, {32'd0, exp_ts[1][31:0]});
    // R5 lowest free, R8 full
    rx_pkt(2, 1, 0, 1, 0, "R5 refill slot0");
    rx_pkt(2, 1, 0, 1, 2, "R5 slot2");
    rx_pkt(2, 1, 0, 1, 3, "R5 slot3");
    keep = exp_ts[2];
    rx_pkt(2, 1, 0, 0, 0, "R8 pool full");
    rd(5'h2, d); chk("R8 status full", {32'd0, d}, 64'hF);
    rd(5'd13, d); chk("R8 slot2 kept", {32'd0, d}, {32'd0, keep[63:32]});
    rx_pkt(2, 0, 0, 1, 2, "R8 freed slot reused");
    rd(5'd9, d); rd(5'd11, d); rd(5'd13, d); rd(5'd15, d);
    rd(5'h2, d); chk("R7 all freed", {32'd0, d}, 0);
    // R4 udp off
    wr(5'h1, 32'h8000_0002);
    rx_pkt(2, 1, 0, 0, 0, "R4 udp off");
    rx_pkt(2, 0, 0, 1, 0, "R4 l2 with udp off");
    // R3
    wr(5'h1, 32'h8000_0001);
    rx_pkt(1, 1, 0, 0, 0, "R3 v1 udp off");
    wr(5'h1, 32'h8000_0511);
    rd(5'h1, d); chk("R2 ctrl1 readback", {32'd0, d}, 64'h8000_0511);
    rx_pkt(1, 1, 5, 1, 1, "R3 v1 udp match");
    rx_pkt(1, 0, 5, 0, 0, "R3 v1 not udp");
    rx_pkt(1, 1, 4, 0, 0, "R3 v1 msg mismatch");
    rd(5'd11, d); chk("R3 v1 stamp hi", {32'd0, d}, {32'd0, exp_ts[1][63:32]});
    // R2 unknown version
    wr(5'h1, 32'h8000_0013);
    rx_pkt(2, 0, 0, 0, 0, "R2 ver3 l2");
    rx_pkt(1, 1, 0, 0, 0, "R2 ver3 v1");
    // R9 / R10
    wr(5'h1, 32'h8000_0012);
    wr(5'h0, 32'h0);
    tx_pkt(0, "R10 irq disabled");
    rd(5'h2, d); chk("R9 status tx bit", {32'd0, d}, 64'h101);
    keep = tx_exp;
    tx_pkt(0, "R9 second strobe");
    rd(5'h4, d); chk("R9 tx lo", {32'd0, d}, {32'd0, keep[31:0]});
    rd(5'h5, d); chk("R9 tx hi", {32'd0, d}, {32'd0, keep[63:32]});
    rd(5'h2, d); chk("R9 tx freed", {32'd0, d}, 64'h1);
    wr(5'h0, 32'h1);
    tx_pkt(1, "R10 irq enabled");
    rd(5'h4, d); chk("R9 new tx lo", {32'd0, d}, {32'd0, tx_exp[31:0]});
    rd(5'h5, d);
    wr(5'h1, 32'h0000_0012);
    tx_pkt(0, "R9 tx disabled");
    rd(5'h2, d); chk("R9 no tx capture when off", {32'd0, d}, 64'h1);

    repeat (3) @(negedge clk);
    chk("R5 all reports seen", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule